// File: doc/BRIEF.md
# Configurable RAM Window Address Decoder

The decoder sits between a CPU address path and a RAM array of up to 8 MB. A 32-bit size configuration register holds a 3-bit window code. That code decides how much of the 8 MB RAM mirror region is backed by real memory. Above the memory it may leave a stretch that floats (high-Z). Everything above that is unmapped. Each access is classified into exactly one of these three classes. A RAM access gets a RAM-relative byte address that can drive an attached array directly. Reads that land elsewhere return all ones, and writes that land elsewhere are dropped.

The mirror region can be reached through three address segments: the user segment (`3'b000` in bits 31:29), the cached kernel segment (`3'b100`) and the uncached kernel segment (`3'b101`). The segment bits are stripped before the region is decoded.

A DMA-side comparison uses the same memory limit. It flags a bus error for any request whose end (start plus length) reaches or passes the limit, and that error drops the busy flag of the requesting channel.

Top module: `ram_window_decoder`

## Requirements
- R1: After reset the register reads 0x00000B88, which is window code 5, the mapped limit is 0x800000, and every channel busy flag is 0.
- R2: A write stores all 32 bits, and a read returns the full stored value unchanged. The register holds its value while no write occurs.
- R3: The window code in register bits 11:9 sets (memory size, high-Z end): 0 gives (1 MB, 1 MB), 1 gives (4 MB, 4 MB), 2 gives (1 MB, 2 MB), 3 gives (4 MB, 8 MB), 4 gives (2 MB, 2 MB), 5 and 7 give (8 MB, 8 MB), and 6 gives (2 MB, 4 MB). The mapped limit output equals the memory size.
- R4: A write that leaves bits 11:9 unchanged does not change the mapped limit or the decoding.
- R5: Only addresses with bits 31:29 equal to 000, 100 or 101 and bits 28:23 equal to zero are decoded. All other addresses, including everything in the 0xC0000000 segment, raise no class output.
- R6: For a decoded valid access with offset addr[22:0], the offset selects the class. An offset below the memory size is `ram_hit`. An offset from the memory size up to the high-Z end is `highz_hit`. An offset at or above the high-Z end is `unmapped_hit`. At most one class is active, and none is active while `acc_valid` is low.
- R7: On `ram_hit`, `ram_addr` equals addr[22:0], and otherwise it is 0. `ram_we` is high only for a write that is a `ram_hit`, so writes to the high-Z or unmapped classes are discarded.
- R8: `acc_rdata` passes `ram_rdata` on `ram_hit` and returns 0xFFFFFFFF otherwise.
- R9: `dma_bus_err` is high when `dma_req` is high and `dma_addr + dma_len` (computed without overflow) is greater than or equal to the mapped limit.
- R10: Channel busy flag i is set by `dma_go[i]` and cleared by `dma_done[i]`. A bus error on channel i clears it, and the error takes priority over a `dma_go` in the same cycle.
- R11: A write that changes the window code takes effect on the mapped limit, the decoding and the DMA check from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Stored register value |
| map_limit | output | 24 | Registered memory limit in bytes |
| acc_valid | input | 1 | CPU access valid |
| acc_write | input | 1 | CPU access is a write |
| acc_addr | input | 32 | CPU virtual address |
| ram_rdata | input | 32 | Read data from the attached RAM |
| acc_rdata | output | 32 | Read data returned to the CPU |
| ram_hit | output | 1 | Access falls in backed memory |
| highz_hit | output | 1 | Access falls in the floating range |
| unmapped_hit | output | 1 | Access falls in the unmapped range |
| ram_addr | output | 23 | RAM-relative byte address |
| ram_we | output | 1 | Write enable to the RAM |
| dma_req | input | 1 | DMA transfer check request |
| dma_ch | input | CHW | Requesting channel index |
| dma_addr | input | 24 | DMA start address |
| dma_len | input | 24 | DMA transfer length in bytes |
| dma_go | input | NCH | Per-channel start pulses |
| dma_done | input | NCH | Per-channel completion pulses |
| dma_bus_err | output | 1 | Bus error for the current request |
| dma_busy | output | NCH | Per-channel busy flags |

## Verification
The assertions check four properties on every cycle: the three class outputs never overlap, a RAM hit never produces an address beyond the mapped limit, a non-RAM class always reads all ones, and the register and limit stay put without a write or across a write that keeps the window code. They also check that a bus error leaves the requesting channel idle on the next cycle. Only the bench scenarios can show that each window code yields its exact memory and high-Z boundaries. They also show which segments decode, that the limit switches exactly one cycle after the write, and that the DMA comparison turns on at equality rather than one byte later.

// File: rtl/ram_window_decoder.sv
module ram_window_decoder #(
  parameter int NCH = 7,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int LW = 24
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [31:0]     cfg_wdata,
  output logic [31:0]     cfg_rdata,
  output logic [LW-1:0]   map_limit,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic [31:0]     acc_addr,
  input  logic [31:0]     ram_rdata,
  output logic [31:0]     acc_rdata,
  output logic            ram_hit,
  output logic            highz_hit,
  output logic            unmapped_hit,
  output logic [LW-2:0]   ram_addr,
  output logic            ram_we,
  input  logic            dma_req,
  input  logic [CHW-1:0]  dma_ch,
  input  logic [LW-1:0]   dma_addr,
  input  logic [LW-1:0]   dma_len,
  input  logic [NCH-1:0]  dma_go,
  input  logic [NCH-1:0]  dma_done,
  output logic            dma_bus_err,
  output logic [NCH-1:0]  dma_busy
);
  localparam logic [LW-1:0] MB1 = LW'(1) << 20;
  localparam logic [LW-1:0] FULL = MB1 << 3;
  localparam logic [31:0] RST_VAL = 32'h0000_0B88;

  function automatic logic [LW-1:0] mem_size(input logic [2:0] c);
    case (c)
      3'd0, 3'd2: return MB1;
      3'd1, 3'd3: return MB1 << 2;
      3'd4, 3'd6: return MB1 << 1;
      default:    return FULL;
    endcase
  endfunction

  function automatic logic [LW-1:0] hz_end(input logic [2:0] c);
    case (c)
      3'd0:       return MB1;
      3'd1:       return MB1 << 2;
      3'd2, 3'd4: return MB1 << 1;
      3'd6:       return MB1 << 2;
      default:    return FULL;
    endcase
  endfunction

  logic [31:0]   cfg_q;
  logic [LW-1:0] mem_lim_q, hz_lim_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= RST_VAL;
      mem_lim_q <= mem_size(RST_VAL[11:9]);
      hz_lim_q  <= hz_end(RST_VAL[11:9]);
    end else if (cfg_we) begin
      cfg_q <= cfg_wdata;
      if (cfg_wdata[11:9] != cfg_q[11:9]) begin
        mem_lim_q <= mem_size(cfg_wdata[11:9]);
        hz_lim_q  <= hz_end(cfg_wdata[11:9]);
      end
    end
  end

  assign cfg_rdata = cfg_q;
  assign map_limit = mem_lim_q;

  logic          seg_ok, in_mirror;
  logic [LW-1:0] off;

  assign seg_ok    = (acc_addr[31:29] == 3'b000) || (acc_addr[31:29] == 3'b100) ||
                     (acc_addr[31:29] == 3'b101);
  assign in_mirror = acc_valid && seg_ok && (acc_addr[28:23] == '0);
  assign off       = {1'b0, acc_addr[22:0]};

  assign ram_hit      = in_mirror && (off < mem_lim_q);
  assign highz_hit    = in_mirror && (off >= mem_lim_q) && (off < hz_lim_q);
  assign unmapped_hit = in_mirror && (off >= hz_lim_q);
  assign ram_addr     = ram_hit ? acc_addr[22:0] : '0;
  assign ram_we       = ram_hit && acc_write;
  assign acc_rdata    = ram_hit ? ram_rdata : '1;

  logic [LW:0] dma_end;
  assign dma_end     = {1'b0, dma_addr} + {1'b0, dma_len};
  assign dma_bus_err = dma_req && (dma_end >= {1'b0, mem_lim_q});

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk) begin
      if (!rst_n)                                   dma_busy[i] <= 1'b0;
      else if (dma_bus_err && (dma_ch == CHW'(i)))  dma_busy[i] <= 1'b0;
      else if (dma_go[i])                           dma_busy[i] <= 1'b1;
      else if (dma_done[i])                         dma_busy[i] <= 1'b0;
    end
  end
endmodule

module ram_window_decoder_chk #(
  parameter int NCH = 7,
  parameter int CHW = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cfg_we,
  input logic [31:0]    cfg_wdata,
  input logic [31:0]    cfg_rdata,
  input logic [23:0]    map_limit,
  input logic [31:0]    acc_rdata,
  input logic           ram_hit,
  input logic           highz_hit,
  input logic           unmapped_hit,
  input logic [22:0]    ram_addr,
  input logic [CHW-1:0] dma_ch,
  input logic           dma_bus_err,
  input logic [NCH-1:0] dma_busy
);
  p_class_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ram_hit, highz_hit, unmapped_hit}));

  p_ram_in_limit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ram_hit |-> ({1'b0, ram_addr} < map_limit));

  p_fill_ones_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (highz_hit || unmapped_hit) |-> (acc_rdata == 32'hFFFF_FFFF));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_rdata));

  p_same_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && (cfg_wdata[11:9] == cfg_rdata[11:9])) |=> $stable(map_limit));

  p_err_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dma_bus_err |=> !dma_busy[$past(dma_ch)]);
endmodule

bind ram_window_decoder ram_window_decoder_chk #(.NCH(NCH), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
  .cfg_rdata(cfg_rdata), .map_limit(map_limit), .acc_rdata(acc_rdata),
  .ram_hit(ram_hit), .highz_hit(highz_hit), .unmapped_hit(unmapped_hit),
  .ram_addr(ram_addr), .dma_ch(dma_ch), .dma_bus_err(dma_bus_err),
  .dma_busy(dma_busy)
);

// File: tb/test_ram_window_decoder.sv
module test_ram_window_decoder;
  localparam int NCH = 7;
  localparam int CHW = 3;
  localparam logic [31:0] MB = 32'h0010_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0, cfg_rdata;
  logic [23:0] map_limit;
  logic acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0, ram_rdata = 32'h5A5A_1234, acc_rdata;
  logic ram_hit, highz_hit, unmapped_hit, ram_we;
  logic [22:0] ram_addr;
  logic dma_req = 1'b0;
  logic [CHW-1:0] dma_ch = '0;
  logic [23:0] dma_addr = '0, dma_len = '0;
  logic [NCH-1:0] dma_go = '0, dma_done = '0, dma_busy;
  logic dma_bus_err;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  ram_window_decoder #(.NCH(NCH)) i_ram_window_decoder (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_mem(input int c);
    case (c)
      0, 2: return MB;
      1, 3: return 4 * MB;
      4, 6: return 2 * MB;
      default: return 8 * MB;
    endcase
  endfunction

  function automatic logic [31:0] exp_hz(input int c);
    case (c)
      0: return MB;
      2, 4: return 2 * MB;
      1, 6: return 4 * MB;
      default: return 8 * MB;
    endcase
  endfunction

  task automatic wr_cfg(input logic [31:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  // cls: 0 none, 1 ram, 2 highz, 3 unmapped
  task automatic probe(input logic [31:0] a, input bit w, input int cls, input string req);
    @(negedge clk); acc_valid = 1'b1; acc_write = w; acc_addr = a;
    #1;
    chk({ram_hit, highz_hit, unmapped_hit} == 3'((cls == 1) ? 4 : (cls == 2) ? 2 : (cls == 3) ? 1 : 0),
        req, {29'd0, ram_hit, highz_hit, unmapped_hit}, a);
    if (cls == 1) begin
      chk(ram_addr == a[22:0], "R7 ram_addr", {9'd0, ram_addr}, {9'd0, a[22:0]});
      chk(ram_we == w, "R7 ram_we", {31'd0, ram_we}, {31'd0, w});
      if (!w) chk(acc_rdata == ram_rdata, "R8 ram data", acc_rdata, ram_rdata);
    end else begin
      chk(ram_we == 1'b0, "R7 discard write", {31'd0, ram_we}, 0);
      chk(acc_rdata == '1, "R8 fill ones", acc_rdata, 32'hFFFF_FFFF);
    end
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(cfg_rdata == 32'h0000_0B88, "R1 reset value", cfg_rdata, 32'h0000_0B88);
    chk(map_limit == 24'h80_0000, "R1 reset limit", {8'd0, map_limit}, 32'h0080_0000);
    chk(dma_busy == '0, "R1 busy idle", {25'd0, dma_busy}, 0);
  endtask

  task automatic t_windows;
    for (int c = 0; c < 8; c++) begin
      logic [31:0] m, h;
      m = exp_mem(c); h = exp_hz(c);
      wr_cfg(32'h0000_0188 | (c << 9));
      chk(map_limit == m[23:0], "R3 limit", {8'd0, map_limit}, m);
      probe(32'h8000_0000 | (m - 1), 1'b0, 1, "R6 last ram byte");
      if (h > m) begin
        probe(m, 1'b0, 2, "R6 first highz byte");
        probe(32'hA000_0000 | (h - 1), 1'b1, 2, "R6 last highz byte");
      end else if (m < 8 * MB) probe(m, 1'b0, 3, "R6 first unmapped after ram");
      if (h < 8 * MB) probe(h, 1'b1, 3, "R6 first unmapped byte");
    end
  endtask

  task automatic t_other_bits;
    wr_cfg(32'h0000_0800);
    wr_cfg(32'hDEAD_A9FF);
    chk(cfg_rdata == 32'hDEAD_A9FF, "R2 readback", cfg_rdata, 32'hDEAD_A9FF);
    chk(map_limit == 24'h20_0000, "R4 limit kept", {8'd0, map_limit}, 32'h0020_0000);
    probe(32'h0020_0000, 1'b0, 3, "R4 decode kept");
    repeat (3) @(negedge clk);
    chk(cfg_rdata == 32'hDEAD_A9FF, "R2 hold", cfg_rdata, 32'hDEAD_A9FF);
  endtask

  task automatic t_segments;
    wr_cfg(32'h0000_0A00);
    probe(32'h0000_1234, 1'b0, 1, "R5 user seg");
    probe(32'h8012_3454, 1'b1, 1, "R5 cached seg");
    probe(32'hA07F_FFFC, 1'b0, 1, "R5 uncached seg");
    probe(32'hC000_1234, 1'b0, 0, "R5 seg at C0000000");
    probe(32'h2000_1234, 1'b0, 0, "R5 user above mirror");
    probe(32'h8080_0000, 1'b0, 0, "R5 beyond 8MB");
    @(negedge clk); acc_valid = 1'b0; acc_addr = 32'h0000_0010; #1;
    chk({ram_hit, highz_hit, unmapped_hit} == 3'b000, "R6 idle no class", {29'd0, ram_hit, highz_hit, unmapped_hit}, 0);
  endtask

  task automatic t_timing;
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = 32'h0000_0000;
    dma_req = 1'b1; dma_addr = 24'h10_0000; dma_len = 24'h0;
    #1;
    chk(map_limit == 24'h80_0000, "R11 old limit in write cycle", {8'd0, map_limit}, 32'h0080_0000);
    chk(dma_bus_err == 1'b0, "R11 old DMA check", {31'd0, dma_bus_err}, 0);
    @(posedge clk); #1;
    chk(map_limit == 24'h10_0000, "R11 new limit next cycle", {8'd0, map_limit}, 32'h0010_0000);
    chk(dma_bus_err == 1'b1, "R11 new DMA check", {31'd0, dma_bus_err}, 1);
    @(negedge clk); cfg_we = 1'b0; dma_req = 1'b0;
  endtask

  task automatic t_dma;
    wr_cfg(32'h0000_0800);
    @(negedge clk); dma_go = 7'b0001100;
    @(negedge clk); dma_go = '0;
    chk(dma_busy == 7'b0001100, "R10 go sets busy", {25'd0, dma_busy}, 32'h0C);
    dma_req = 1'b1; dma_ch = 3'd2; dma_addr = 24'h1F_FF00; dma_len = 24'h0FF; #1;
    chk(dma_bus_err == 1'b0, "R9 below limit", {31'd0, dma_bus_err}, 0);
    @(negedge clk); dma_len = 24'h100; #1;
    chk(dma_bus_err == 1'b1, "R9 equal limit", {31'd0, dma_bus_err}, 1);
    @(negedge clk); dma_req = 1'b0;
    chk(dma_busy == 7'b0001000, "R10 error clears channel", {25'd0, dma_busy}, 32'h08);
    dma_req = 1'b1; dma_ch = 3'd5; dma_addr = 24'hFF_FFFF; dma_len = 24'hFF_FFFF; dma_go = 7'b0100000;
    @(negedge clk); dma_req = 1'b0; dma_go = '0;
    chk(dma_busy == 7'b0001000, "R10 error beats go, R9 no wrap", {25'd0, dma_busy}, 32'h08);
    dma_done = 7'b0001000;
    @(negedge clk); dma_done = '0;
    chk(dma_busy == '0, "R10 done clears", {25'd0, dma_busy}, 0);
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_windows();
    t_other_bits();
    t_segments();
    t_timing();
    t_dma();
    finish_run();
  end

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 1, 0);
    finish_run();
  end
endmodule